// File: doc/BRIEF.md
# Transmit End-of-Interrupt Command Handler

This block closes a transmit interrupt for one channel of a serial communications controller. The host's service routine ends with a single byte write to this write-only command register. That one write does several things in the same cycle. It pops the interrupt context stack. It can discard the current DMA transmit buffer. It can flag end of frame or an empty transfer to the transmit FIFO logic. In synchronous operation it can also load one of two general-purpose down-counting timers from a timer value byte held in a status register.

Each accepted write is captured on the clock edge where `wr_en` is high. The command FSM moves from `C_IDLE` to `C_EXEC` and drives every command pulse for exactly one cycle, then returns to `C_IDLE`. A write that arrives during `C_EXEC` keeps the FSM in `C_EXEC` for another cycle.

A discard issued while an end-of-buffer interrupt is being closed must also remove the following buffer. A second FSM tracks this with three states:
- `D_IDLE`
- `D_ARMED`: entered on arm
- `D_FIRE`: entered from `D_ARMED` on `next_buf`, and lasts one cycle

From `D_FIRE` the FSM goes back to `D_IDLE`, or to `D_ARMED` if a new arm arrives in that cycle.

Each timer runs its own FSM with two states:
- `T_IDLE`: the count stays where it is.
- `T_RUN`: the count drops by one on each prescale `tick`.

A timer goes from `T_IDLE` to `T_RUN` when it is loaded with a nonzero value. It goes from `T_RUN` back to `T_IDLE` when the count reaches zero, or when it is loaded with zero. Reaching zero raises the timer-group interrupt once.

Top module: `tx_eoi_handler`

## Requirements
- R1: While reset is asserted, and until the first write, every pulse output is low, `disc_pending` is low, and both timer counts are zero.
- R2: Every write pulses `ctx_pop` high for exactly one cycle, in the cycle after the write edge. `ctx_pop` never rises without a write.
- R3: Bit 7 of the written byte, with `dma_mode`=1, pulses `buf_discard` in the same cycle as `ctx_pop`. With `dma_mode`=0 bit 7 produces no discard.
- R4: Bit 7 with `dma_mode`=1 while `irq_type`=2'b01 (transmit end of buffer) sets `disc_pending` from the cycle after the pop. The next `next_buf` pulse clears it, and `buf_discard` pulses in the cycle after that `next_buf`. `irq_type` codes: 2'b00 data transfer, 2'b01 end of buffer, 2'b10 other, 2'b11 none.
- R5: Bit 6 pulses `frame_end` with the pop only when `sync_mode`=1 and `dma_mode`=0.
- R6: Bit 5 with `sync_mode`=1 loads timer 2 with `timer_val`. The new value is visible on `tmr2_cnt` in the cycle after the pop.
- R7: Bit 4 with `sync_mode`=1 loads timer 1 with `timer_val` in its high byte and zero in its low byte. The new value is visible on `tmr1_cnt` in the cycle after the pop.
- R8: A running timer decrements by one on each cycle where `tick` is high, and stops at zero. `tmr_irq` is high for one cycle: the first cycle in which a loaded nonzero count reads zero. A load of zero raises no interrupt. A new load overrides a running count.
- R9: Bit 3 pulses `no_xfer` with the pop, in any mode.
- R10: A write with any of bits 2..0 nonzero pulses `rsvd_err` with the pop. All other actions of that write are still carried out.
- R11: With `sync_mode`=0, bits 6, 5 and 4 are ignored: no `frame_end`, and both timer counts are unchanged. The pop, the bit 7 actions and the bit 3 action still occur.
- R12: The outputs depend only on the value captured with each write. `irq_type`, `sync_mode`, `dma_mode` and `timer_val` are sampled on the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe for the command register |
| wr_data | input | 8 | Command byte |
| irq_type | input | 2 | Kind of interrupt being closed |
| sync_mode | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| dma_mode | input | 1 | 1 = DMA data transfer, 0 = interrupt-driven |
| timer_val | input | 8 | Timer value byte from the interrupt status register |
| next_buf | input | 1 | DMA path starts the next transmit buffer |
| tick | input | 1 | Timer prescale tick |
| ctx_pop | output | 1 | Pop one interrupt context entry |
| buf_discard | output | 1 | Discard request to the DMA path |
| disc_pending | output | 1 | Discard carried to the next buffer is armed |
| frame_end | output | 1 | Last data of the frame or block |
| no_xfer | output | 1 | No data was written to the FIFO |
| rsvd_err | output | 1 | Reserved bits were written nonzero |
| tmr_irq | output | 1 | Timer-group interrupt request |
| tmr1_cnt | output | 16 | Timer 1 count |
| tmr2_cnt | output | 8 | Timer 2 count |

## Verification
Every bit of the command byte is exercised one at a time and in combination. Each bit is tried under asynchronous mode, synchronous interrupt-driven mode and synchronous DMA mode. This separates the mode gating of bits 6..4 from the bits that act in every mode.

Discards are issued both while closing an end-of-buffer interrupt and while closing a data-transfer interrupt. This shows whether the carry to the next buffer is tied to the interrupt kind. Reserved-bit writes that also set action bits show that the error flag does not block those actions.

The timers are loaded with small values, with a high-byte value of one (256 ticks), and with zero. A count is also reloaded while it is running. Together these tell apart decrement, stop at zero, single interrupt and load priority.

// File: rtl/tx_eoi_pkg.sv
package tx_eoi_pkg;

    localparam int CMD_W = 8;

    // interrupt kind being closed
    typedef enum logic [1:0] {
        IRQ_XFER  = 2'b00,
        IRQ_EOB   = 2'b01,
        IRQ_OTHER = 2'b10,
        IRQ_NONE  = 2'b11
    } irq_kind_e;

    // decoded command byte, bit 7 down to bit 0
    typedef struct packed {
        logic       term;
        logic       eof;
        logic       set_t2;
        logic       set_t1;
        logic       notx;
        logic [2:0] rsvd;
    } eoi_cmd_t;

    typedef enum logic {
        C_IDLE,
        C_EXEC
    } cmd_state_e;

    typedef enum logic [1:0] {
        D_IDLE,
        D_ARMED,
        D_FIRE
    } carry_state_e;

    typedef enum logic {
        T_IDLE,
        T_RUN
    } tmr_state_e;

endpackage

// File: rtl/eoi_cmd_fsm.sv
module eoi_cmd_fsm
    import tx_eoi_pkg::*;
#(
    parameter int DW = CMD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    irq_type,
    input  logic          sync_mode,
    input  logic          dma_mode,
    input  logic [DW-1:0] timer_val,
    output logic          ctx_pop,
    output logic          cur_discard,
    output logic          arm_carry,
    output logic          frame_end,
    output logic          no_xfer,
    output logic          rsvd_err,
    output logic          load_t1,
    output logic          load_t2,
    output logic [DW-1:0] load_val
);

    cmd_state_e      state_q, state_d;
    eoi_cmd_t        cmd_q;
    logic            sync_q;
    logic            dma_q;
    irq_kind_e       kind_q;
    logic [DW-1:0]   val_q;

    // state register and write capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
            cmd_q   <= '0;
            sync_q  <= 1'b0;
            dma_q   <= 1'b0;
            kind_q  <= IRQ_NONE;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en) begin
                cmd_q  <= eoi_cmd_t'(wr_data[7:0]);
                sync_q <= sync_mode;
                dma_q  <= dma_mode;
                kind_q <= irq_kind_e'(irq_type);
                val_q  <= timer_val;
            end
        end
    end

    // transitions: C_IDLE -> C_EXEC on write, C_EXEC -> C_IDLE otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE: if (wr_en) state_d = C_EXEC;
            C_EXEC: state_d = wr_en ? C_EXEC : C_IDLE;
            default: state_d = C_IDLE;
        endcase
    end

    // outputs: every action lasts the single C_EXEC cycle
    always_comb begin
        ctx_pop     = 1'b0;
        cur_discard = 1'b0;
        arm_carry   = 1'b0;
        frame_end   = 1'b0;
        no_xfer     = 1'b0;
        rsvd_err    = 1'b0;
        load_t1     = 1'b0;
        load_t2     = 1'b0;
        load_val    = val_q;
        unique case (state_q)
            C_IDLE: ;
            C_EXEC: begin
                ctx_pop     = 1'b1;
                cur_discard = cmd_q.term && dma_q;
                arm_carry   = cmd_q.term && dma_q && (kind_q == IRQ_EOB);
                frame_end   = cmd_q.eof && sync_q && !dma_q;
                no_xfer     = cmd_q.notx;
                rsvd_err    = |cmd_q.rsvd;
                load_t1     = cmd_q.set_t1 && sync_q;
                load_t2     = cmd_q.set_t2 && sync_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/discard_carry_fsm.sv
module discard_carry_fsm
    import tx_eoi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic next_buf,
    output logic fire,
    output logic pending
);

    carry_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= D_IDLE;
        else        state_q <= state_d;
    end

    // D_IDLE -arm-> D_ARMED -next_buf-> D_FIRE -> D_IDLE (or D_ARMED on arm)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            D_IDLE:  if (arm) state_d = D_ARMED;
            D_ARMED: if (next_buf) state_d = D_FIRE;
            D_FIRE:  state_d = arm ? D_ARMED : D_IDLE;
            default: state_d = D_IDLE;
        endcase
    end

    always_comb begin
        fire    = 1'b0;
        pending = 1'b0;
        unique case (state_q)
            D_IDLE:  ;
            D_ARMED: pending = 1'b1;
            D_FIRE:  fire    = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/gp_down_timer.sv
module gp_down_timer
    import tx_eoi_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         zero_irq
);

    localparam logic [W-1:0] ONE = W'(1);

    tmr_state_e   state_q, state_d;
    logic [W-1:0] cnt_q;
    logic         irq_q;
    logic         last_tick;

    assign last_tick = (state_q == T_RUN) && tick && (cnt_q == ONE);

    // T_IDLE -load nonzero-> T_RUN -count hits zero-> T_IDLE; load wins
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = (load_val != '0) ? T_RUN : T_IDLE;
        end else begin
            unique case (state_q)
                T_IDLE: ;
                T_RUN:  if (last_tick) state_d = T_IDLE;
                default: state_d = T_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= !load && last_tick;
            if (load)
                cnt_q <= load_val;
            else if (state_q == T_RUN && tick)
                cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt      = cnt_q;
    assign zero_irq = irq_q;

endmodule

// File: rtl/tx_eoi_handler.sv
module tx_eoi_handler
    import tx_eoi_pkg::*;
#(
    parameter int DW   = CMD_W,
    parameter int T1_W = 16,
    parameter int T2_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic [1:0]      irq_type,
    input  logic            sync_mode,
    input  logic            dma_mode,
    input  logic [DW-1:0]   timer_val,
    input  logic            next_buf,
    input  logic            tick,
    output logic            ctx_pop,
    output logic            buf_discard,
    output logic            disc_pending,
    output logic            frame_end,
    output logic            no_xfer,
    output logic            rsvd_err,
    output logic            tmr_irq,
    output logic [T1_W-1:0] tmr1_cnt,
    output logic [T2_W-1:0] tmr2_cnt
);

    localparam int T1_PAD = T1_W - DW;

    logic            cur_discard;
    logic            arm_carry;
    logic            carry_fire;
    logic            load_t1;
    logic            load_t2;
    logic [DW-1:0]   load_val;
    logic [T1_W-1:0] t1_val;
    logic [T2_W-1:0] t2_val;
    logic            z1;
    logic            z2;

    eoi_cmd_fsm #(.DW(DW)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .irq_type    (irq_type),
        .sync_mode   (sync_mode),
        .dma_mode    (dma_mode),
        .timer_val   (timer_val),
        .ctx_pop     (ctx_pop),
        .cur_discard (cur_discard),
        .arm_carry   (arm_carry),
        .frame_end   (frame_end),
        .no_xfer     (no_xfer),
        .rsvd_err    (rsvd_err),
        .load_t1     (load_t1),
        .load_t2     (load_t2),
        .load_val    (load_val)
    );

    discard_carry_fsm u_carry (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm_carry),
        .next_buf (next_buf),
        .fire     (carry_fire),
        .pending  (disc_pending)
    );

    // timer 1 takes the byte into its high part
    assign t1_val = {load_val, {T1_PAD{1'b0}}};
    assign t2_val = T2_W'(load_val);

    gp_down_timer #(.W(T1_W)) u_tmr1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_t1),
        .load_val (t1_val),
        .tick     (tick),
        .cnt      (tmr1_cnt),
        .zero_irq (z1)
    );

    gp_down_timer #(.W(T2_W)) u_tmr2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_t2),
        .load_val (t2_val),
        .tick     (tick),
        .cnt      (tmr2_cnt),
        .zero_irq (z2)
    );

    assign buf_discard = cur_discard | carry_fire;
    assign tmr_irq     = z1 | z2;

endmodule

// File: rtl/tx_eoi_checker.sv
module tx_eoi_checker #(
    parameter int DW   = 8,
    parameter int T2_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [DW-1:0]   wr_data,
    input logic            sync_mode,
    input logic            dma_mode,
    input logic            next_buf,
    input logic            ctx_pop,
    input logic            buf_discard,
    input logic            disc_pending,
    input logic            frame_end,
    input logic            no_xfer,
    input logic            rsvd_err,
    input logic [T2_W-1:0] tmr2_cnt
);

    a_r2_pop_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctx_pop);

    a_r2_no_spurious_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !ctx_pop);

    a_r3_discard_source: assert property (@(posedge clk) disable iff (!rst_n)
        buf_discard |-> ($past(wr_en && wr_data[7] && dma_mode) || $past(disc_pending && next_buf)));

    a_r4_carry_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_pending && next_buf) |=> (buf_discard && !disc_pending));

    a_r5_frame_end_gated: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> ($past(wr_en) && $past(wr_data[6]) && $past(sync_mode) && !$past(dma_mode)));

    a_r8_stops_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr2_cnt == '0 && !ctx_pop) |=> (tmr2_cnt == '0));

    a_r9_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3]) |=> no_xfer);

    a_r10_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[2:0] != 3'b000)) |=> rsvd_err);

endmodule

bind tx_eoi_handler tx_eoi_checker #(.DW(DW), .T2_W(T2_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .sync_mode    (sync_mode),
    .dma_mode     (dma_mode),
    .next_buf     (next_buf),
    .ctx_pop      (ctx_pop),
    .buf_discard  (buf_discard),
    .disc_pending (disc_pending),
    .frame_end    (frame_end),
    .no_xfer      (no_xfer),
    .rsvd_err     (rsvd_err),
    .tmr2_cnt     (tmr2_cnt)
);

// File: tb/tx_eoi_handler_tb.sv
`timescale 1ns/1ps
module tx_eoi_handler_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  irq_type = '0;
    logic        sync_mode = 1'b0;
    logic        dma_mode = 1'b0;
    logic [7:0]  timer_val = '0;
    logic        next_buf = 1'b0;
    logic        tick = 1'b0;
    logic        ctx_pop, buf_discard, disc_pending, frame_end, no_xfer, rsvd_err, tmr_irq;
    logic [15:0] tmr1_cnt;
    logic [7:0]  tmr2_cnt;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit tick_en = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tx_eoi_handler u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_type(irq_type), .sync_mode(sync_mode), .dma_mode(dma_mode),
        .timer_val(timer_val), .next_buf(next_buf), .tick(tick),
        .ctx_pop(ctx_pop), .buf_discard(buf_discard), .disc_pending(disc_pending),
        .frame_end(frame_end), .no_xfer(no_xfer), .rsvd_err(rsvd_err),
        .tmr_irq(tmr_irq), .tmr1_cnt(tmr1_cnt), .tmr2_cnt(tmr2_cnt)
    );

    // ---------------- behavioural reference ----------------
    bit        m_cv, m_sync, m_dma, m_eob, m_pend, m_fire, m_z1, m_z2, m_a1, m_a2;
    bit [7:0]  m_b, m_val;
    int        m_t1, m_t2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cv = 0; m_sync = 0; m_dma = 0; m_eob = 0; m_pend = 0; m_fire = 0;
            m_z1 = 0; m_z2 = 0; m_a1 = 0; m_a2 = 0; m_b = 0; m_val = 0;
            m_t1 = 0; m_t2 = 0;
        end else begin
            bit ld1, ld2, arm;
            ld1 = m_cv && m_sync && m_b[4];
            ld2 = m_cv && m_sync && m_b[5];
            arm = m_cv && m_b[7] && m_dma && m_eob;
            if (ld1) begin
                m_t1 = m_val * 256; m_a1 = (m_t1 != 0); m_z1 = 0;
            end else if (tick && m_a1) begin
                m_t1 = m_t1 - 1; m_z1 = (m_t1 == 0); if (m_t1 == 0) m_a1 = 0;
            end else m_z1 = 0;
            if (ld2) begin
                m_t2 = m_val; m_a2 = (m_t2 != 0); m_z2 = 0;
            end else if (tick && m_a2) begin
                m_t2 = m_t2 - 1; m_z2 = (m_t2 == 0); if (m_t2 == 0) m_a2 = 0;
            end else m_z2 = 0;
            m_fire = m_pend && next_buf;
            m_pend = arm ? 1'b1 : (m_pend && !next_buf);
            if (wr_en) begin
                m_cv = 1; m_b = wr_data; m_sync = sync_mode; m_dma = dma_mode;
                m_eob = (irq_type == 2'b01); m_val = timer_val;
            end else m_cv = 0;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            cyc++;
            tick <= tick_en && (cyc % 3 == 0);
            chk("R2 ctx_pop",      32'(ctx_pop),      32'(m_cv));
            chk("R3 buf_discard",  32'(buf_discard),  32'((m_cv && m_b[7] && m_dma) || m_fire));
            chk("R4 disc_pending", 32'(disc_pending), 32'(m_pend));
            chk("R5 frame_end",    32'(frame_end),    32'(m_cv && m_b[6] && m_sync && !m_dma));
            chk("R9 no_xfer",      32'(no_xfer),      32'(m_cv && m_b[3]));
            chk("R10 rsvd_err",    32'(rsvd_err),     32'(m_cv && (m_b[2:0] != 0)));
            chk("R8 tmr_irq",      32'(tmr_irq),      32'(m_z1 || m_z2));
            chk("R7 tmr1_cnt",     32'(tmr1_cnt),     32'(m_t1));
            chk("R6 tmr2_cnt",     32'(tmr2_cnt),     32'(m_t2));
        end
    end

    // watchdog
    initial begin
        #400000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] d, input logic [1:0] it, input logic s,
                      input logic dm, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1; wr_data = d; irq_type = it; sync_mode = s; dma_mode = dm; timer_val = v;
        @(negedge clk);
        wr_en = 0; wr_data = 8'hFF; irq_type = 2'b11; sync_mode = ~s; dma_mode = ~dm; timer_val = 8'hA5;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_next;
        @(negedge clk); next_buf = 1;
        @(negedge clk); next_buf = 0;
    endtask

    initial begin
        logic [15:0] t1_before;
        idle(3);
        // R1: reset state
        chk("R1 outputs", 32'({ctx_pop, buf_discard, disc_pending, frame_end, no_xfer, rsvd_err, tmr_irq}), 0);
        chk("R1 counts", 32'({tmr1_cnt, tmr2_cnt}), 0);
        rst_n = 1;
        idle(2);
        // R2: plain write in async mode
        wr(8'h00, 2'b00, 0, 0, 8'h00);
        idle(2);
        // R3/R4: discard while closing end of buffer, then next buffer
        wr(8'h80, 2'b01, 0, 1, 8'h00);
        idle(3);
        chk("R4 armed", 32'(disc_pending), 1);
        pulse_next();
        idle(3);
        // R3: discard on data-transfer interrupt does not carry
        wr(8'h80, 2'b00, 1, 1, 8'h00);
        pulse_next();
        // R3: no DMA, no discard
        wr(8'h80, 2'b01, 1, 0, 8'h00);
        idle(2);
        // R5: frame end in interrupt-driven sync, not in DMA sync
        wr(8'h40, 2'b00, 1, 0, 8'h00);
        wr(8'h40, 2'b00, 1, 1, 8'h00);
        idle(2);
        // R9, R10
        wr(8'h08, 2'b00, 0, 0, 8'h00);
        wr(8'h0D, 2'b00, 1, 0, 8'h00);
        wr(8'hC7, 2'b01, 1, 1, 8'h00); // R10 with actions still done
        idle(2);
        pulse_next();
        // R6/R8: timer 2 small load and countdown
        tick_en = 1;
        wr(8'h20, 2'b00, 1, 0, 8'h05);
        idle(25);
        chk("R8 t2 stopped", 32'(tmr2_cnt), 0);
        // R7/R8: timer 1 high byte
        wr(8'h10, 2'b00, 1, 0, 8'h01);
        @(negedge clk);
        chk("R7 t1 load", 32'(tmr1_cnt) & 32'hFF00, 32'h0100);
        idle(800);
        // R8: load zero, reload while running
        wr(8'h20, 2'b00, 1, 0, 8'h00);
        idle(5);
        wr(8'h20, 2'b00, 1, 0, 8'h09);
        idle(6);
        wr(8'h20, 2'b00, 1, 0, 8'h03);
        idle(15);
        // R11: async ignores bits 6..4 while timer 1 runs
        wr(8'h10, 2'b00, 1, 0, 8'h02);
        idle(4);
        tick_en = 0;
        idle(3);
        t1_before = tmr1_cnt;
        wr(8'h78, 2'b01, 0, 0, 8'h09);
        chk("R11 frame_end ignored", 32'(frame_end), 0);
        chk("R11 no_xfer kept", 32'(no_xfer), 1);
        idle(2);
        chk("R11 t1 unchanged", 32'(tmr1_cnt), 32'(t1_before));
        chk("R11 t2 unchanged", 32'(tmr2_cnt), 0);
        // R12: inputs changing after the write edge have no effect (wr task scrambles them)
        wr(8'hF8, 2'b01, 0, 1, 8'h33);
        idle(2);
        chk("R12 carry armed from captured kind", 32'(disc_pending), 1);
        pulse_next();
        // back-to-back writes
        wr(8'h08, 2'b00, 0, 0, 8'h00);
        wr(8'h01, 2'b00, 0, 0, 8'h00);
        tick_en = 1;
        idle(800);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule